// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Band and Trip Override

This block is one pulse-width modulation channel for a half-bridge. A counter sweeps up from zero to a programmed period and back down again. A qualified drive level is raised when the counter passes a compare value on the way up and dropped when it passes the same value on the way down. A dead-band stage then builds a complementary high-side and low-side pair from that single level. Each pin is turned on only after a programmable number of cycles, so the two switches are never on together.

Software programs the channel through a write strobe, an address and a data word. The period and both compare values are written to shadow registers. They take effect only at a counter turning point, so a change made mid-cycle never produces a stray edge. A continuous software force acts on the qualified levels, ahead of the dead-band stage. As a result, a force-low with the dead-band stage enabled still leaves one pin high. Two ways drive both pins low together: disabling the dead-band stage together with a force-low on both channels, or the trip input. The trip input latches, overrides everything after the dead-band stage, and is released by a write. A one-cycle start-of-conversion pulse marks each arrival of the counter at the period value.

Top module: `pwm_db_channel`

## Requirements
- R1: During reset and after it, until any register is written, pwmA, pwmB and socPulse are 0.
- R2: The counter runs 0, 1, ..., P, P-1, ..., 1, 0 and repeats, where P is the active period (address 0). With the start-of-conversion enable (address 4 bit 1) set, socPulse is high for exactly one cycle, the cycle after the counter equals P, so once every 2P cycles. With the enable clear, socPulse stays 0.
- R3: With the dead-band enable (address 4 bit 0) clear, pwmA follows the qualified A level and pwmB follows the qualified B level. A rises the cycle after the counter equals compare A (address 1) while counting up, and falls the cycle after it equals compare A while counting down. B does the same with compare B (address 2).
- R4: A compare value that is written becomes active only when the counter next equals zero or the period. Until then, edges keep following the previous value.
- R5: A written period becomes active only when the counter next equals zero.
- R6: With dead-band enabled, pwmA rises after the qualified A level has been high for RED cycles (address 5, 10 bits), and falls in the same cycle as the level. A high run of RED cycles or fewer leaves pwmA low. A RED of 0 passes the edge with no delay.
- R7: With dead-band enabled, pwmB rises after the qualified A level has been low for FED cycles (address 6, 10 bits), and falls in the same cycle the level rises. pwmA and pwmB are never both high.
- R8: Address 3 holds the force codes: bits [1:0] for A and bits [3:2] for B. Code 1 forces the qualified level low, code 2 forces it high, and codes 0 and 3 leave it untouched. A force acts from the cycle after the write.
- R9: When A is forced low with dead-band enabled, pwmA is 0 and pwmB is 1 once FED cycles have passed. When both channels are forced low with dead-band disabled, both pins are 0.
- R10: While tripIn is high, both pins are 0 in the same cycle. A trip remains latched after tripIn falls, keeping both pins at 0, until a write to address 7. After that, normal output resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| tripIn | input | 1 | Trip request, forces both pins low and latches |
| pwmA | output | 1 | High-side drive |
| pwmB | output | 1 | Low-side drive |
| socPulse | output | 1 | One-cycle start-of-conversion pulse |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter and 10-bit dead-band delays. It then programs a period of 6, briefly 4, so a full up-down cycle spans only 12 clocks. With such a short cycle, the bench can sweep every compare value inside the period against every rising and falling delay from 0 to 7. That sweep includes delays longer than the high or low run, where a pulse must be swallowed. Expected pin levels come from the cycle's phase, which is anchored on the start-of-conversion pulse. The same short period makes it cheap to time shadow reloads and period changes to the exact cycle.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_PRD  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_CMPA = 3'd1;
  localparam logic [ADR_W-1:0] ADR_CMPB = 3'd2;
  localparam logic [ADR_W-1:0] ADR_FRC  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_CFG  = 3'd4;
  localparam logic [ADR_W-1:0] ADR_RED  = 3'd5;
  localparam logic [ADR_W-1:0] ADR_FED  = 3'd6;
  localparam logic [ADR_W-1:0] ADR_TRIP = 3'd7;

  typedef enum logic [1:0] {
    FRC_NONE  = 2'd0,
    FRC_LOW   = 2'd1,
    FRC_HIGH  = 2'd2,
    FRC_NONE2 = 2'd3
  } frc_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic setA;
    logic clrA;
    logic setB;
    logic clrB;
    logic tripClr;
  } pwm_strobe_t;

  // Static configuration seen by the datapath
  typedef struct packed {
    frc_e forceA;
    frc_e forceB;
    logic dbEn;
  } pwm_cfg_t;

endpackage

// File: rtl/pwm_db_ctrl.sv
module pwm_db_ctrl
  import pwm_db_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output pwm_strobe_t      strb,
  output pwm_cfg_t         cfg,
  output logic [DB_W-1:0]  redDly,
  output logic [DB_W-1:0]  fedDly,
  output logic             socPulse
);

  logic [CNT_W-1:0] prdSh, prdAct;
  logic [CNT_W-1:0] cmpASh, cmpAAct;
  logic [CNT_W-1:0] cmpBSh, cmpBAct;
  logic [CNT_W-1:0] cnt;
  logic             dirUp;
  logic             socEn;
  logic             zeroEvt, prdEvt;

  // Register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdSh  <= '0;
      cmpASh <= '1;
      cmpBSh <= '1;
      cfg    <= '0;
      socEn  <= 1'b0;
      redDly <= '0;
      fedDly <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_PRD:  prdSh  <= wrData;
        ADR_CMPA: cmpASh <= wrData;
        ADR_CMPB: cmpBSh <= wrData;
        ADR_FRC: begin
          cfg.forceA <= frc_e'(wrData[1:0]);
          cfg.forceB <= frc_e'(wrData[3:2]);
        end
        ADR_CFG: begin
          cfg.dbEn <= wrData[0];
          socEn    <= wrData[1];
        end
        ADR_RED:  redDly <= wrData[DB_W-1:0];
        ADR_FED:  fedDly <= wrData[DB_W-1:0];
        default:  ;
      endcase
    end
  end

  assign zeroEvt = (cnt == '0);
  assign prdEvt  = (cnt == prdAct);

  // Shadow reloads at the turning points
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdAct  <= '0;
      cmpAAct <= '1;
      cmpBAct <= '1;
    end else begin
      if (zeroEvt) prdAct <= prdSh;
      if (zeroEvt || prdEvt) begin
        cmpAAct <= cmpASh;
        cmpBAct <= cmpBSh;
      end
    end
  end

  // Symmetric up-down time base
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (prdAct == '0) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (dirUp) begin
      if (cnt >= prdAct) begin
        dirUp <= 1'b0;
        cnt   <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (zeroEvt) begin
        dirUp <= 1'b1;
        cnt   <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) socPulse <= 1'b0;
    else       socPulse <= socEn && prdEvt;
  end

  always_comb begin
    strb.setA    = dirUp  && (cnt == cmpAAct);
    strb.clrA    = !dirUp && (cnt == cmpAAct);
    strb.setB    = dirUp  && (cnt == cmpBAct);
    strb.clrB    = !dirUp && (cnt == cmpBAct);
    strb.tripClr = wrEn && (wrAddr == ADR_TRIP);
  end

endmodule

// File: rtl/pwm_db_edge_dly.sv
module pwm_db_edge_dly #(
  parameter int DB_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            srcIn,
  input  logic [DB_W-1:0] dly,
  output logic            dlyOut
);

  // Length of the current high run of srcIn, saturating
  logic [DB_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !srcIn) runCnt <= '0;
    else if (runCnt != '1) runCnt <= runCnt + 1'b1;
  end

  assign dlyOut = srcIn && (runCnt >= dly);

endmodule

// File: rtl/pwm_db_dpath.sv
module pwm_db_dpath
  import pwm_db_pkg::*;
#(
  parameter int DB_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  pwm_strobe_t     strb,
  input  pwm_cfg_t        cfg,
  input  logic [DB_W-1:0] redDly,
  input  logic [DB_W-1:0] fedDly,
  input  logic            tripIn,
  output logic            pwmA,
  output logic            pwmB
);

  localparam int NUM_EDGE = 2;

  logic aqA, aqB;
  logic srcA, srcB;
  logic tripLatch, tripAct;
  logic [NUM_EDGE-1:0] edgeSrc, edgeOut;
  logic [DB_W-1:0]     edgeDly [NUM_EDGE];

  function automatic logic applyForce(frc_e f, logic v);
    case (f)
      FRC_LOW:  return 1'b0;
      FRC_HIGH: return 1'b1;
      default:  return v;
    endcase
  endfunction

  // Action qualifier
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aqA <= 1'b0;
      aqB <= 1'b0;
    end else begin
      if (strb.setA)      aqA <= 1'b1;
      else if (strb.clrA) aqA <= 1'b0;
      if (strb.setB)      aqB <= 1'b1;
      else if (strb.clrB) aqB <= 1'b0;
    end
  end

  // Software force sits ahead of the dead-band stage
  assign srcA = applyForce(cfg.forceA, aqA);
  assign srcB = applyForce(cfg.forceB, aqB);

  // Index 0: delayed rise of A; index 1: delayed rise of not-A (low side)
  assign edgeSrc    = {~srcA, srcA};
  assign edgeDly[0] = redDly;
  assign edgeDly[1] = fedDly;

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
    pwm_db_edge_dly #(.DB_W(DB_W)) edge_i (
      .clk    (clk),
      .rstN   (rstN),
      .srcIn  (edgeSrc[g]),
      .dly    (edgeDly[g]),
      .dlyOut (edgeOut[g])
    );
  end

  // Trip override after the dead-band stage
  always_ff @(posedge clk) begin
    if (!rstN)             tripLatch <= 1'b0;
    else if (tripIn)       tripLatch <= 1'b1;
    else if (strb.tripClr) tripLatch <= 1'b0;
  end

  assign tripAct = tripIn || tripLatch;
  assign pwmA = !tripAct && (cfg.dbEn ? edgeOut[0] : srcA);
  assign pwmB = !tripAct && (cfg.dbEn ? edgeOut[1] : srcB);

endmodule

// File: rtl/pwm_db_channel.sv
module pwm_db_channel
  import pwm_db_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tripIn,
  output logic             pwmA,
  output logic             pwmB,
  output logic             socPulse
);

  pwm_strobe_t     strb;
  pwm_cfg_t        cfg;
  logic [DB_W-1:0] redDly, fedDly;

  pwm_db_ctrl #(.CNT_W(CNT_W), .DB_W(DB_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .cfg      (cfg),
    .redDly   (redDly),
    .fedDly   (fedDly),
    .socPulse (socPulse)
  );

  pwm_db_dpath #(.DB_W(DB_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfg    (cfg),
    .redDly (redDly),
    .fedDly (fedDly),
    .tripIn (tripIn),
    .pwmA   (pwmA),
    .pwmB   (pwmB)
  );

endmodule

// File: rtl/pwm_db_chk.sv
module pwm_db_chk
  import pwm_db_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [ADR_W-1:0] wrAddr,
  input logic             tripIn,
  input logic             pwmA,
  input logic             pwmB,
  input pwm_cfg_t         cfg
);

  logic pastOk;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assert_trip_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |-> (!pwmA && !pwmB));

  assert_trip_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $fell(tripIn) && !$past(wrEn && (wrAddr == ADR_TRIP)))
      |-> (!pwmA && !pwmB));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.dbEn |-> !(pwmA && pwmB));

  assert_force_low_db_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dbEn && (cfg.forceA == FRC_LOW)) |-> !pwmA);

  assert_force_high_db_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dbEn && (cfg.forceA == FRC_HIGH)) |-> !pwmB);

  assert_force_low_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.dbEn && (cfg.forceA == FRC_LOW) && (cfg.forceB == FRC_LOW))
      |-> (!pwmA && !pwmB));

endmodule

bind pwm_db_channel pwm_db_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .tripIn (tripIn),
  .pwmA   (pwmA),
  .pwmB   (pwmB),
  .cfg    (cfg)
);

// File: tb/pwm_db_channel_tb_top.sv
`timescale 1ns/1ps
module pwm_db_channel_tb_top;

  localparam int P = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        tripIn = 1'b0;
  logic        pwmA, pwmB, socPulse;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwm_db_channel dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .tripIn   (tripIn),
    .pwmA     (pwmA),
    .pwmB     (pwmB),
    .socPulse (socPulse)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chkInt(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write
  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic anchor();
    int guard = 0;
    while (socPulse !== 1'b1 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic settle(input int n);
    repeat (n * 2 * P) @(negedge clk);
  endtask

  function automatic bit aqOn(int ph, int c, int p);
    return (ph >= c + 1) && (ph <= 2 * p - c);
  endfunction

  function automatic bit dbA(int ph, int c, int p, int red);
    return aqOn(ph, c, p) && (ph - c - 1 >= red);
  endfunction

  function automatic bit dbB(int ph, int c, int p, int fed);
    return !aqOn(ph, c, p) && (((ph - (2 * p - c + 1) + 2 * p) % (2 * p)) >= fed);
  endfunction

  // Starts on the sample where socPulse is high (phase P+1)
  task automatic checkPeriod(input bit db, input int c, input int cb,
                             input int red, input int fed,
                             input string tagA, input string tagB);
    for (int k = 0; k < 2 * P; k++) begin
      int ph;
      ph = (P + 1 + k) % (2 * P);
      if (db) begin
        chk(pwmA, dbA(ph, c, P, red), tagA);
        chk(pwmB, dbB(ph, c, P, fed), tagB);
      end else begin
        chk(pwmA, aqOn(ph, c, P), tagA);
        chk(pwmB, aqOn(ph, cb, P), tagB);
      end
      chk(socPulse, ph == P + 1, "R2 soc");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int k;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pwmA, 1'b0, "R1 reset A");
    chk(pwmB, 1'b0, "R1 reset B");
    chk(socPulse, 1'b0, "R1 reset soc");
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(pwmA, 1'b0, "R1 idle A");
      chk(pwmB, 1'b0, "R1 idle B");
      chk(socPulse, 1'b0, "R1 idle soc");
    end

    // Pass-through setup
    wr(1, 2); wr(2, 3); wr(0, P); wr(4, 2);
    anchor(); settle(2);
    checkPeriod(0, 2, 3, 0, 0, "R3 A", "R3 B");

    // R2 soc disabled
    wr(4, 0);
    @(negedge clk);
    repeat (4 * P) begin
      chk(socPulse, 1'b0, "R2 soc off");
      @(negedge clk);
    end
    wr(4, 2);

    // R3 sweep of both compares
    for (int c = 1; c < P; c++) begin
      for (int cb = 1; cb < P; cb++) begin
        wr(1, c); wr(2, cb);
        anchor(); settle(2);
        checkPeriod(0, c, cb, 0, 0, "R3 A", "R3 B");
      end
    end

    // R4 compare shadow: write at phase P+1, takes effect at next zero
    wr(1, 2); wr(2, 3);
    anchor(); settle(2);
    wrEn = 1'b1; wrAddr = 3'd1; wrData = 16'd4;
    @(negedge clk);
    wrEn = 1'b0;
    for (int j = 0; j < 3 * P - 2; j++) begin
      int ph;
      int cu;
      ph = (P + 2 + j) % (2 * P);
      cu = (P + 2 + j < 2 * P) ? 2 : 4;
      chk(pwmA, aqOn(ph, cu, P), "R4 shadow A");
      @(negedge clk);
    end
    wr(1, 2);

    // R5 period shadow
    anchor(); settle(2);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 16'd4;
    @(negedge clk);
    wrEn = 1'b0;
    k = 1;
    while (socPulse !== 1'b1 && k < 100) begin
      @(negedge clk);
      k++;
    end
    chkInt(k, P + 4, "R5 first interval");
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (socPulse !== 1'b1 && k < 100);
    chkInt(k, 8, "R5 new interval");
    wr(0, P);
    anchor(); settle(1);
    anchor();
    checkPeriod(0, 2, 3, 0, 0, "R5 restored A", "R5 restored B");

    // R6/R7 dead-band sweep
    wr(4, 3);
    for (int c = 1; c < P; c++) begin
      for (int red = 0; red < 8; red++) begin
        for (int fed = 0; fed < 8; fed++) begin
          wr(1, c); wr(5, red); wr(6, fed);
          anchor(); settle(2);
          checkPeriod(1, c, 0, red, fed, "R6 A", "R7 B");
        end
      end
    end

    // R8/R9 force with dead-band enabled
    wr(1, 2); wr(5, 1); wr(6, 1);
    anchor(); settle(1);
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 16'h5;
    @(negedge clk);
    wrEn = 1'b0;
    chk(pwmA, 1'b0, "R8 immediate force low");
    repeat (10) begin
      @(negedge clk);
      chk(pwmA, 1'b0, "R9 forced A low");
      chk(pwmB, 1'b1, "R9 complementary B high");
    end
    wr(3, 16'h2);
    repeat (10) begin
      @(negedge clk);
      chk(pwmA, 1'b1, "R8 forced A high");
      chk(pwmB, 1'b0, "R8 forced A high B low");
    end
    wr(3, 16'hF);
    anchor(); settle(2);
    checkPeriod(1, 2, 0, 1, 1, "R8 code3 A", "R8 code3 B");

    // R8/R9 force with dead-band disabled
    wr(4, 2);
    wr(3, 16'h5);
    repeat (10) begin
      @(negedge clk);
      chk(pwmA, 1'b0, "R9 pass both low A");
      chk(pwmB, 1'b0, "R9 pass both low B");
    end
    wr(3, 16'hA);
    repeat (10) begin
      @(negedge clk);
      chk(pwmA, 1'b1, "R8 pass high A");
      chk(pwmB, 1'b1, "R8 pass high B");
    end
    wr(3, 0);

    // R10 trip
    wr(4, 3);
    anchor(); settle(1);
    tripIn = 1'b1;
    @(negedge clk);
    chk(pwmA, 1'b0, "R10 trip A");
    chk(pwmB, 1'b0, "R10 trip B");
    tripIn = 1'b0;
    repeat (2 * P) begin
      @(negedge clk);
      chk(pwmA, 1'b0, "R10 latched A");
      chk(pwmB, 1'b0, "R10 latched B");
    end
    wr(7, 0);
    anchor();
    checkPeriod(1, 2, 0, 1, 1, "R10 resume A", "R10 resume B");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule